// File: doc/BRIEF.md
# TDM Routing RAM Entry Sequencer

This block walks a time-division-multiplexed serial interface through the entries of its routing RAM. It keeps one sequencer for the receive direction and one for the transmit direction. Each sequencer holds a pair of 5-bit entry pointers, a and b. Only the pointer of the bank in use counts, and the other is held at zero. A frame-sync pulse starts both sequencers at entry 0 of their current bank. After that, each entry-done strobe moves the pointer on by one. When the done strobe arrives with the entry's last-entry flag set, the pointer goes back to 0 instead.

The mode field picks one of two bank rules. In 64-entry mode the a half and the b half together form one long table: reaching the last entry of one half hands control to the other half. In dual-bank mode one bank is live and the other is a shadow that can be rewritten meanwhile. A bank-switch request is held pending and takes effect only at the end-of-frame wrap of the live pointer.

Each direction outputs a RAM address of bank base plus pointer times four, and a bank bit. A read-only 32-bit word shows all four pointers together with their valid bits.

Top module: `tdm_entry_seq`

## Requirements
- R1: Each entry-done strobe without the last flag, on an active direction, advances that direction's live pointer by one, modulo 32, and leaves the bank unchanged.
- R2: An entry-done strobe with the last flag set returns the live pointer to 0 on the next cycle, so a last flag on the fifth entry makes the pointer run 0 to 4.
- R3: In mode 2'b00, a last-flagged done moves the direction from the a half to the b half, or from the b half back to the a half. The pointer of the idle half always reads 0.
- R4: In mode 2'b01, a bank-switch request pulse, taken only while the mode is 2'b01, is held pending for each direction. The bank changes only on that direction's next last-flagged done, and that change clears the pending request. With no request pending, the bank does not change.
- R5: The receive address is bank*128 + pointer*4, covering 0..127 for bank a and 128..255 for bank b. The transmit address is 256 + bank*128 + pointer*4, covering 256..383 and 384..511.
- R6: The bank output of a direction is 0 for bank a and 1 for bank b. Once a direction has seen a frame sync, exactly the valid bit of its current bank is 1. Before that, both valid bits are 0.
- R7: The status word has transmit-b in bits 31:24, receive-b in bits 23:16, transmit-a in bits 15:8 and receive-a in bits 7:0. Each byte is {2'b00, valid, pointer[4:0]}.
- R8: Both the asynchronous reset and the synchronous soft reset clear the status word, the bank bits and the addresses. Done strobes before the first frame sync have no effect.
- R9: A frame-sync pulse puts both directions at entry 0 of their current bank. It takes priority over a done strobe in the same cycle.
- R10: Mode values 2'b10 and 2'b11 follow the 64-entry rule of mode 2'b00, and in those modes a bank-switch request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous soft reset, active high |
| mode_i | input | 2 | 00 64-entry, 01 dual-bank, 1x as 00 |
| frame_sync_i | input | 1 | Frame start pulse |
| bank_sw_i | input | 1 | Bank-switch request pulse (dual-bank mode) |
| rx_done_i | input | 1 | Receive entry processed |
| rx_last_i | input | 1 | Last-entry flag of current receive entry |
| tx_done_i | input | 1 | Transmit entry processed |
| tx_last_i | input | 1 | Last-entry flag of current transmit entry |
| rx_addr_o | output | 9 | Current receive RAM address |
| tx_addr_o | output | 9 | Current transmit RAM address |
| rx_bank_o | output | 1 | Receive current bank (0 a, 1 b) |
| tx_bank_o | output | 1 | Transmit current bank (0 a, 1 b) |
| status_o | output | 32 | Pointer status word |

## Verification
The case hardest to reach from the ports is a pending dual-bank switch meeting the end-of-frame wrap. The bench has to show two things: the bank holds through a full frame with no request, and it holds through mid-frame dones after a request. It then has to show that both directions switch on their own later wraps, and that a second wrap does not switch again because the request was consumed. The stimulus does this with a request pulse raised between two frames, followed by ordinary and last-flagged dones in a fixed order. A separate 32-strobe run with no last flag drives the pointer through its natural modulo-32 rollover.

// File: rtl/tdm_seq_pkg.sv
package tdm_seq_pkg;
  typedef enum logic [1:0] {
    MODE_SPLIT64 = 2'b00,
    MODE_DUAL    = 2'b01,
    MODE_RSV2    = 2'b10,
    MODE_RSV3    = 2'b11
  } seq_mode_e;
endpackage

// File: rtl/tdm_dir_seq.sv
module tdm_dir_seq
  import tdm_seq_pkg::*;
#(
  parameter int PTR_W       = 5,
  parameter int ENTRY_SHIFT = 2,
  parameter int ADDR_W      = PTR_W + ENTRY_SHIFT + 2,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic [1:0]        mode_i,
  input  logic              sync_i,
  input  logic              done_i,
  input  logic              last_i,
  input  logic              sw_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              bank_o,
  output logic [1:0]        valid_o,
  output logic [PTR_W-1:0]  ptr_a_o,
  output logic [PTR_W-1:0]  ptr_b_o
);
  logic             act_q, bank_q, pend_q;
  logic [PTR_W-1:0] ptr_a_q, ptr_b_q, cur_ptr;
  logic             dual, step, wrap, flip;

  assign dual    = (seq_mode_e'(mode_i) == MODE_DUAL);
  assign cur_ptr = bank_q ? ptr_b_q : ptr_a_q;
  assign step    = act_q && done_i && !sync_i;
  assign wrap    = step && last_i;
  assign flip    = wrap && (dual ? pend_q : 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      bank_q  <= 1'b0;
      pend_q  <= 1'b0;
      ptr_a_q <= '0;
      ptr_b_q <= '0;
    end else if (srst_i) begin
      act_q   <= 1'b0;
      bank_q  <= 1'b0;
      pend_q  <= 1'b0;
      ptr_a_q <= '0;
      ptr_b_q <= '0;
    end else begin
      pend_q <= (pend_q && !(flip && dual)) || (sw_i && dual);
      if (sync_i) begin
        act_q   <= 1'b1;
        ptr_a_q <= '0;
        ptr_b_q <= '0;
      end else if (step) begin
        if (last_i) begin
          ptr_a_q <= '0;
          ptr_b_q <= '0;
          bank_q  <= bank_q ^ flip;
        end else if (bank_q) begin
          ptr_a_q <= '0;
          ptr_b_q <= ptr_b_q + 1'b1;
        end else begin
          ptr_a_q <= ptr_a_q + 1'b1;
          ptr_b_q <= '0;
        end
      end
    end
  end

  assign addr_o  = BASE + ADDR_W'({bank_q, cur_ptr, {ENTRY_SHIFT{1'b0}}});
  assign bank_o  = bank_q;
  assign valid_o = {act_q && bank_q, act_q && !bank_q};
  assign ptr_a_o = ptr_a_q;
  assign ptr_b_o = ptr_b_q;

  AST_PTR_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !last_i && !srst_i) |=>
      ((cur_ptr - $past(cur_ptr)) == PTR_W'(1)) && $stable(bank_q)); // R1
  AST_WRAP_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && !srst_i) |=> (ptr_a_q == '0) && (ptr_b_q == '0)); // R2
  AST_IDLE_PTR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_q ? ptr_a_q : ptr_b_q) == '0); // R3
  AST_DUAL_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dual && !srst_i && !(wrap && pend_q)) |=> $stable(bank_q)); // R4
endmodule

// File: rtl/tdm_status_word.sv
module tdm_status_word #(
  parameter int PTR_W  = 5,
  parameter int BYTE_W = 8
) (
  input  logic [1:0]         rx_valid_i,
  input  logic [1:0]         tx_valid_i,
  input  logic [PTR_W-1:0]   rx_ptr_a_i,
  input  logic [PTR_W-1:0]   rx_ptr_b_i,
  input  logic [PTR_W-1:0]   tx_ptr_a_i,
  input  logic [PTR_W-1:0]   tx_ptr_b_i,
  output logic [4*BYTE_W-1:0] word_o
);
  localparam int PAD_W = BYTE_W - 1 - PTR_W;

  // byte order MSB first: tx-b, rx-b, tx-a, rx-a
  assign word_o = {{PAD_W{1'b0}}, tx_valid_i[1], tx_ptr_b_i,
                   {PAD_W{1'b0}}, rx_valid_i[1], rx_ptr_b_i,
                   {PAD_W{1'b0}}, tx_valid_i[0], tx_ptr_a_i,
                   {PAD_W{1'b0}}, rx_valid_i[0], rx_ptr_a_i};
endmodule

// File: rtl/tdm_entry_seq.sv
module tdm_entry_seq #(
  parameter int PTR_W       = 5,
  parameter int ENTRY_SHIFT = 2,
  parameter int ADDR_W      = PTR_W + ENTRY_SHIFT + 2,
  parameter int STAT_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic [1:0]        mode_i,
  input  logic              frame_sync_i,
  input  logic              bank_sw_i,
  input  logic              rx_done_i,
  input  logic              rx_last_i,
  input  logic              tx_done_i,
  input  logic              tx_last_i,
  output logic [ADDR_W-1:0] rx_addr_o,
  output logic [ADDR_W-1:0] tx_addr_o,
  output logic              rx_bank_o,
  output logic              tx_bank_o,
  output logic [STAT_W-1:0] status_o
);
  localparam int NDIR = 2;  // 0 receive, 1 transmit

  logic [NDIR-1:0]   done_v, last_v, bank_v;
  logic [ADDR_W-1:0] addr_w  [NDIR];
  logic [1:0]        valid_w [NDIR];
  logic [PTR_W-1:0]  ptra_w  [NDIR];
  logic [PTR_W-1:0]  ptrb_w  [NDIR];

  assign done_v = {tx_done_i, rx_done_i};
  assign last_v = {tx_last_i, rx_last_i};

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    tdm_dir_seq #(
      .PTR_W      (PTR_W),
      .ENTRY_SHIFT(ENTRY_SHIFT),
      .ADDR_W     (ADDR_W),
      .BASE       (ADDR_W'(g) << (ADDR_W - 1))
    ) u_seq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .srst_i (soft_rst_i),
      .mode_i (mode_i),
      .sync_i (frame_sync_i),
      .done_i (done_v[g]),
      .last_i (last_v[g]),
      .sw_i   (bank_sw_i),
      .addr_o (addr_w[g]),
      .bank_o (bank_v[g]),
      .valid_o(valid_w[g]),
      .ptr_a_o(ptra_w[g]),
      .ptr_b_o(ptrb_w[g])
    );
  end

  tdm_status_word #(.PTR_W(PTR_W), .BYTE_W(STAT_W / 4)) u_stat (
    .rx_valid_i(valid_w[0]),
    .tx_valid_i(valid_w[1]),
    .rx_ptr_a_i(ptra_w[0]),
    .rx_ptr_b_i(ptrb_w[0]),
    .tx_ptr_a_i(ptra_w[1]),
    .tx_ptr_b_i(ptrb_w[1]),
    .word_o    (status_o)
  );

  assign rx_addr_o = addr_w[0];
  assign tx_addr_o = addr_w[1];
  assign rx_bank_o = bank_v[0];
  assign tx_bank_o = bank_v[1];

  AST_SRST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (status_o == '0) && !rx_bank_o && !tx_bank_o); // R8
  AST_BANK_AGREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_o[21] || rx_bank_o) && (!status_o[5] || !rx_bank_o) &&
    (!status_o[29] || tx_bank_o) && (!status_o[13] || !tx_bank_o)); // R6
  AST_VALID_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({status_o[21], status_o[5]}) && $onehot0({status_o[29], status_o[13]})); // R6
endmodule

// File: tb/tdm_entry_seq_tb.sv
`timescale 1ns/1ps
module tdm_entry_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic srst = 1'b0, sync = 1'b0, sw = 1'b0;
  logic rxd = 1'b0, rxl = 1'b0, txd = 1'b0, txl = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [8:0] rx_addr, tx_addr;
  logic rx_bank, tx_bank;
  logic [31:0] status;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // reference model, index 0 receive, 1 transmit
  bit m_act[2], m_bank[2], m_pend[2];
  logic [4:0] m_ptr[2];

  always #4 clk = ~clk;

  tdm_entry_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(srst), .mode_i(mode),
    .frame_sync_i(sync), .bank_sw_i(sw), .rx_done_i(rxd), .rx_last_i(rxl),
    .tx_done_i(txd), .tx_last_i(txl), .rx_addr_o(rx_addr), .tx_addr_o(tx_addr),
    .rx_bank_o(rx_bank), .tx_bank_o(tx_bank), .status_o(status)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(input int d, input bit b);
    return {2'b00, m_act[d] && (m_bank[d] == b), (m_bank[d] == b) ? m_ptr[d] : 5'd0};
  endfunction

  function automatic logic [8:0] maddr(input int d);
    return 9'(d * 256 + int'(m_bank[d]) * 128 + int'(m_ptr[d]) * 4);
  endfunction

  task automatic compare_all(input string tag);
    chk({tag, " R5 rx_addr"}, 32'(rx_addr), 32'(maddr(0)));
    chk({tag, " R5 tx_addr"}, 32'(tx_addr), 32'(maddr(1)));
    chk({tag, " R6 rx_bank"}, 32'(rx_bank), 32'(m_bank[0]));
    chk({tag, " R6 tx_bank"}, 32'(tx_bank), 32'(m_bank[1]));
    chk({tag, " R7 status"}, status, {mbyte(1, 1), mbyte(0, 1), mbyte(1, 0), mbyte(0, 0)});
  endtask

  task automatic step(input string tag, input bit sy, input bit rd, input bit rl,
                      input bit td, input bit tl, input bit s, input bit sr);
    bit dn[2], ls[2];
    bit dual;
    sync = sy; rxd = rd; rxl = rl; txd = td; txl = tl; sw = s; srst = sr;
    dn[0] = rd; dn[1] = td; ls[0] = rl; ls[1] = tl;
    dual = (mode == 2'b01);
    @(posedge clk);
    for (int d = 0; d < 2; d++) begin
      if (sr) begin
        m_act[d] = 0; m_bank[d] = 0; m_pend[d] = 0; m_ptr[d] = '0;
      end else begin
        bit applied;
        applied = 0;
        if (sy) begin
          m_act[d] = 1; m_ptr[d] = '0;
        end else if (m_act[d] && dn[d]) begin
          if (ls[d]) begin
            m_ptr[d] = '0;
            if (!dual || m_pend[d]) begin
              m_bank[d] = !m_bank[d];
              applied = dual;
            end
          end else begin
            m_ptr[d] = m_ptr[d] + 5'd1;
          end
        end
        m_pend[d] = (m_pend[d] && !applied) || (s && dual);
      end
    end
    @(negedge clk);
    sync = 0; rxd = 0; rxl = 0; txd = 0; txl = 0; sw = 0; srst = 0;
    compare_all(tag);
  endtask

  task automatic t_reset();
    chk("R8 reset status", status, 32'h0);
    chk("R8 reset rx_addr", 32'(rx_addr), 32'd0);
    chk("R8 reset tx_addr", 32'(tx_addr), 32'd256);
    step("R8 done before sync", 0, 1, 0, 1, 1, 0, 0);
    chk("R8 done ignored", status, 32'h0);
  endtask

  task automatic t_wrap();
    mode = 2'b00;
    step("R8 srst", 0, 0, 0, 0, 0, 0, 1);
    step("R9 sync", 1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step("R1 count", 0, 1, 0, 0, 0, 0, 0);
    chk("R5 rx entry 4 addr", 32'(rx_addr), 32'd16);
    step("R2 last on 5th", 0, 1, 1, 0, 0, 0, 0);
    chk("R2 rx wrapped to b", 32'(rx_addr), 32'd128);
    chk("R3 rx bank b", 32'(rx_bank), 32'd1);
    chk("R7 layout after wrap", status, 32'h0020_2000);
  endtask

  task automatic t_split();
    mode = 2'b00;
    step("R8 srst", 0, 0, 0, 0, 0, 0, 1);
    step("R9 sync", 1, 0, 0, 0, 0, 0, 0);
    step("R1 s1", 0, 1, 0, 1, 0, 0, 0);
    step("R3 s2", 0, 1, 0, 1, 1, 0, 0);
    step("R1 s3", 0, 1, 0, 1, 0, 0, 0);
    step("R1 s4", 0, 0, 0, 1, 0, 0, 0);
    chk("R7 txb=2 rxa=3", status, 32'h2200_0023);
    chk("R5 tx b entry 2", 32'(tx_addr), 32'd392);
    step("R3 back to a", 0, 0, 0, 1, 1, 0, 0);
    chk("R3 tx bank a", 32'(tx_bank), 32'd0);
    chk("R5 tx a entry 0", 32'(tx_addr), 32'd256);
  endtask

  task automatic t_dual();
    mode = 2'b01;
    step("R8 srst", 0, 0, 0, 0, 0, 0, 1);
    step("R9 sync", 1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 32; i++) step("R1 run", 0, 0, 0, 1, 0, 0, 0);
    chk("R1 modulo 32", 32'(tx_addr), 32'd256);
    step("R4 a", 0, 1, 0, 0, 0, 0, 0);
    step("R4 b", 0, 1, 0, 0, 0, 0, 0);
    step("R4 wrap no req", 0, 1, 1, 0, 0, 0, 0);
    chk("R4 bank held", 32'(rx_bank), 32'd0);
    step("R4 request", 0, 0, 0, 0, 0, 1, 0);
    step("R4 mid frame", 0, 1, 0, 0, 0, 0, 0);
    chk("R4 no early switch", 32'(rx_bank), 32'd0);
    step("R4 rx wrap", 0, 1, 1, 0, 0, 0, 0);
    chk("R5 rx bank b base", 32'(rx_addr), 32'd128);
    step("R4 tx wrap", 0, 0, 0, 1, 1, 0, 0);
    chk("R5 tx bank b base", 32'(tx_addr), 32'd384);
    chk("R7 both b", status, 32'h2020_0000);
    step("R4 consumed", 0, 1, 1, 1, 1, 0, 0);
    chk("R4 stays b", 32'({rx_bank, tx_bank}), 32'd3);
  endtask

  task automatic t_sync();
    mode = 2'b00;
    step("R8 srst", 0, 0, 0, 0, 0, 0, 1);
    step("R9 sync", 1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step("R1 pre", 0, 1, 0, 1, 0, 0, 0);
    step("R9 sync wins", 1, 1, 0, 1, 0, 0, 0);
    chk("R9 rx restart", 32'(rx_addr), 32'd0);
    chk("R9 status restart", status, 32'h0000_2020);
  endtask

  task automatic t_mode_other();
    mode = 2'b10;
    step("R8 srst", 0, 0, 0, 0, 0, 0, 1);
    step("R9 sync", 1, 0, 0, 0, 0, 0, 0);
    step("R10 req ignored", 0, 0, 0, 0, 0, 1, 0);
    step("R10 auto flip", 0, 1, 1, 0, 0, 0, 0);
    chk("R10 rx b", 32'(rx_bank), 32'd1);
    mode = 2'b01;
    step("R10 no stale req", 0, 1, 1, 0, 0, 0, 0);
    chk("R10 stays b", 32'(rx_bank), 32'd1);
    mode = 2'b11;
    step("R10 flip back", 0, 1, 1, 0, 0, 0, 0);
    chk("R10 rx a", 32'(rx_bank), 32'd0);
  endtask

  task automatic t_soft_reset();
    step("R1 act", 0, 1, 0, 1, 0, 0, 0);
    step("R8 soft", 0, 1, 0, 1, 0, 0, 1);
    chk("R8 soft clears", status, 32'h0);
    chk("R8 soft rx addr", 32'(rx_addr), 32'd0);
  endtask

  initial begin
    for (int d = 0; d < 2; d++) begin
      m_act[d] = 0; m_bank[d] = 0; m_pend[d] = 0; m_ptr[d] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wrap();
    t_split();
    t_dual();
    t_sync();
    t_mode_other();
    t_soft_reset();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule